// File: doc/BRIEF.md
# Stereo Serial Audio Bit-Clock and Word-Select Generator

This block is the timing master of a two-channel serial audio link. A programmable divider turns the system clock into a continuous bit clock. A slot sequencer then counts bit periods and drives a word-select line: low for the left channel and high for the right. The left and right slot lengths are set separately, so a frame can be asymmetric.

Word select changes on a falling bit-clock edge, one full bit period before the first (most significant) bit of the channel it announces. Receivers therefore see it stable on the next rising edge. The block also emits one-system-clock strobes that local serialisers and deserialisers can use instead of detecting edges themselves: one for each rising bit-clock edge, one for each falling bit-clock edge, one for each word-select change, and one for the start of each channel slot.

Deasserting the enable returns the block to its idle state. The next enable starts a new frame at the left channel.

Top module: `audio_bclk_ws_gen`

## Requirements
- R1: While reset is asserted, and in the cycle after any clock edge at which `en` is sampled low, `bclk`, `ws` and all four strobes are 0.
- R2: With H = max(`half_div`, 1), `bclk` starts low when enabled. It toggles on every H-th system clock edge counted from the first edge with `en` high, and runs continuously with no gaps between words.
- R3: `bclk_rise` is 1 for exactly the cycles in which `bclk` has just gone 0 to 1. `bclk_fall` is 1 for exactly the cycles in which `bclk` has just gone 1 to 0.
- R4: After enable, the first falling `bclk` edge starts bit 0 of the left channel. `ws` is 0 at that point and stays 0 until then.
- R5: `ws` = 0 marks the left channel and `ws` = 1 marks the right channel. The left slot is L = max(`left_len`, 1) bit periods, the right slot is R = max(`right_len`, 1), and frames repeat every L+R bit periods.
- R6: `ws` changes only on a falling `bclk` edge. It takes the channel of the bit period that follows the one just started, so it changes exactly one bit period before each slot's first bit.
- R7: `slot_start` pulses with `bclk_fall` on the falling edge that begins the first bit of each left and right slot.
- R8: `ws_toggle` pulses in exactly the cycles in which `ws` has just changed while enabled.
- R9: Values of 0 on `half_div`, `left_len` or `right_len` behave as 1.
- R10: Dropping `en` for any time and raising it again restarts the bit clock low and the frame at the left channel, as after reset.
- R11: Slot lengths of 16, 18, 20 and 24 bits, and any length up to 2^SLOT_W-1, are sequenced correctly, including unequal left and right lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run enable; low holds the idle state |
| half_div | input | DIV_W (8) | System clocks per bit-clock phase (0 acts as 1) |
| left_len | input | SLOT_W (6) | Left slot length in bit periods (0 acts as 1) |
| right_len | input | SLOT_W (6) | Right slot length in bit periods (0 acts as 1) |
| bclk | output | 1 | Generated bit clock |
| ws | output | 1 | Word select: 0 left, 1 right |
| bclk_rise | output | 1 | Strobe in the cycle bclk rose |
| bclk_fall | output | 1 | Strobe in the cycle bclk fell |
| ws_toggle | output | 1 | Strobe in the cycle ws changed |
| slot_start | output | 1 | Strobe on the falling edge that starts a slot's first bit |

## Verification
The hardest cases to reach are the degenerate frames: one-bit slots, where `ws` must toggle on every falling edge, and zero settings that have to act as one. Mixed with a divider of one, these put a falling edge on every second system clock. The bench sweeps every combination of small divider and slot settings, including 0 and 1, and then a set of long unequal word lengths. Each output is compared every cycle against a closed-form expression of the edge count. Enable is also dropped mid-frame and raised again, which checks the left-first restart.

// File: rtl/audio_clk_pkg.sv
// Shared types for the serial audio clock generator.
// Assumes: channel encoding matches the word-select line level.
package audio_clk_pkg;
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;
endpackage

// File: rtl/audio_bclk_div.sv
// Bit-clock divider: toggles bclk every max(half_div,1) system clocks while
// enabled and marks each edge with a registered strobe. It also gives a
// combinational look-ahead of the falling edge for the slot sequencer.
// Assumes: half_div may change at any time; a smaller value takes effect
// at once because the count compares with >=.
module audio_bclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half_div,
    output logic             bclk,
    output logic             rise_stb,
    output logic             fall_stb,
    output logic             fall_next
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;
    logic             hit;

    // Last count value of a phase, with 0 treated as a one-cycle phase.
    always_comb begin
        lim       = (half_div == '0) ? '0 : half_div - 1'b1;
        hit       = en && (cnt >= lim);
        fall_next = hit && bclk;
    end

    // Phase counter, bit clock and edge strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt      <= '0;
            bclk     <= 1'b0;
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
        end else if (hit) begin
            cnt      <= '0;
            bclk     <= ~bclk;
            rise_stb <= ~bclk;
            fall_stb <= bclk;
        end else begin
            cnt      <= cnt + 1'b1;
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
        end
    end

    assert_rise_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> (bclk && !$past(bclk)));
    assert_fall_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> (!bclk && $past(bclk)));
endmodule

// File: rtl/audio_slot_seq.sv
// Slot sequencer: advances one bit period on each falling bit-clock edge.
// It tracks the channel and bit index of the period about to start, and
// drives word select to the channel of the period after that, which places
// each change one bit period ahead of the slot's first bit.
// Assumes: fall_tick is a single-cycle look-ahead of the bclk falling edge.
module audio_slot_seq
    import audio_clk_pkg::*;
#(
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              fall_tick,
    input  logic [SLOT_W-1:0] left_len,
    input  logic [SLOT_W-1:0] right_len,
    output logic              ws,
    output logic              ws_stb,
    output logic              msb_stb
);
    chan_e             cur_ch;
    chan_e             nxt_ch;
    logic [SLOT_W-1:0] cur_pos;
    logic [SLOT_W-1:0] nxt_pos;
    logic [SLOT_W-1:0] len_m1;
    logic [SLOT_W-1:0] sel_len;

    // Next channel and position after the period that is starting now.
    always_comb begin
        sel_len = (cur_ch == CH_LEFT) ? left_len : right_len;
        len_m1  = (sel_len == '0) ? '0 : sel_len - 1'b1;
        if (cur_pos >= len_m1) begin
            nxt_ch  = (cur_ch == CH_LEFT) ? CH_RIGHT : CH_LEFT;
            nxt_pos = '0;
        end else begin
            nxt_ch  = cur_ch;
            nxt_pos = cur_pos + 1'b1;
        end
    end

    // Slot state, word select and slot strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cur_ch  <= CH_LEFT;
            cur_pos <= '0;
            ws      <= 1'b0;
            ws_stb  <= 1'b0;
            msb_stb <= 1'b0;
        end else if (fall_tick) begin
            cur_ch  <= nxt_ch;
            cur_pos <= nxt_pos;
            ws      <= nxt_ch;
            ws_stb  <= (nxt_ch != chan_e'(ws));
            msb_stb <= (cur_pos == '0);
        end else begin
            ws_stb  <= 1'b0;
            msb_stb <= 1'b0;
        end
    end

    assert_ws_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && (ws != $past(ws))) |-> $past(fall_tick));
endmodule

// File: rtl/audio_bclk_ws_gen.sv
// Top of the stereo serial audio timing master: a bit-clock divider feeding
// a slot sequencer that produces word select and per-slot strobes.
// Assumes: all configuration inputs are synchronous to clk; change them
// while en is low for a clean frame.
module audio_bclk_ws_gen #(
    parameter int DIV_W  = 8,
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [SLOT_W-1:0] left_len,
    input  logic [SLOT_W-1:0] right_len,
    output logic              bclk,
    output logic              ws,
    output logic              bclk_rise,
    output logic              bclk_fall,
    output logic              ws_toggle,
    output logic              slot_start
);
    logic fall_next;

    audio_bclk_div #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .half_div  (half_div),
        .bclk      (bclk),
        .rise_stb  (bclk_rise),
        .fall_stb  (bclk_fall),
        .fall_next (fall_next)
    );

    audio_slot_seq #(.SLOT_W(SLOT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .fall_tick (fall_next),
        .left_len  (left_len),
        .right_len (right_len),
        .ws        (ws),
        .ws_stb    (ws_toggle),
        .msb_stb   (slot_start)
    );

    assert_edges_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bclk_rise, bclk_fall}));
    assert_slot_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        slot_start |-> bclk_fall);
    assert_toggle_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ws_toggle |-> bclk_fall);
    assert_idle_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!bclk && !ws && !bclk_rise && !slot_start));
endmodule

// File: tb/audio_bclk_ws_gen_bench.sv
module audio_bclk_ws_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] half_div = '0;
    logic [5:0] left_len = '0;
    logic [5:0] right_len = '0;
    logic bclk, ws, bclk_rise, bclk_fall, ws_toggle, slot_start;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    audio_bclk_ws_gen u_audio_bclk_ws_gen (
        .clk(clk), .rst_n(rst_n), .en(en), .half_div(half_div),
        .left_len(left_len), .right_len(right_len), .bclk(bclk), .ws(ws),
        .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
        .ws_toggle(ws_toggle), .slot_start(slot_start)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Channel of bit period k for slot lengths l, r (R5).
    function automatic int chan_of(input int k, input int l, input int r);
        return ((k % (l + r)) >= l) ? 1 : 0;
    endfunction

    // Enable from idle and compare every output for n cycles against the
    // edge-count formula. Optionally drop en at the end (R10).
    task automatic run_cfg(input int hd, input int ll, input int rl);
        int h, l, r, n;
        h = (hd == 0) ? 1 : hd;   // R9
        l = (ll == 0) ? 1 : ll;
        r = (rl == 0) ? 1 : rl;
        n = 2 * h * (2 * (l + r) + 3) + 2;
        @(negedge clk);
        half_div = hd[7:0]; left_len = ll[5:0]; right_len = rl[5:0];
        en = 1'b1;
        for (int t = 1; t <= n; t++) begin
            int tog, falls, k, eb, ews, er, ef, ewt, ess, p;
            @(posedge clk); #1;
            tog   = t / h;
            falls = tog / 2;
            eb    = tog % 2;
            er    = ((t % h) == 0 && eb == 1) ? 1 : 0;
            ef    = ((t % h) == 0 && eb == 0 && tog > 0) ? 1 : 0;
            k     = falls - 1;
            ews   = (falls == 0) ? 0 : chan_of(k + 1, l, r);
            p     = (k >= 0) ? (k % (l + r)) : -1;
            ess   = (ef == 1 && (p == 0 || p == l)) ? 1 : 0;
            ewt   = (ef == 1 && chan_of(k + 1, l, r) != chan_of(k, l, r)) ? 1 : 0;
            check("R2 bclk", int'(bclk), eb);
            check("R3 bclk_rise", int'(bclk_rise), er);
            check("R3 bclk_fall", int'(bclk_fall), ef);
            check("R6 ws", int'(ws), ews);
            check("R7 slot_start", int'(slot_start), ess);
            check("R8 ws_toggle", int'(ws_toggle), ewt);
            if (ef == 1 && k == 0) begin
                check("R4 first slot left", int'(ws), (l == 1) ? 1 : 0);
                check("R4 first slot start", int'(slot_start), 1);
            end
            if (ll >= 16 && ef == 1 && p == l)
                check("R11 right slot begins after long left", int'(slot_start), 1);
        end
        @(negedge clk);
        en = 1'b0;
        @(posedge clk); #1;
        check("R10 idle bclk", int'(bclk), 0);
        check("R10 idle ws", int'(ws), 0);
        check("R10 idle strobes",
              int'({bclk_rise, bclk_fall, ws_toggle, slot_start}), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset bclk", int'(bclk), 0);
        check("R1 reset ws", int'(ws), 0);
        check("R1 reset strobes",
              int'({bclk_rise, bclk_fall, ws_toggle, slot_start}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 idle after reset", int'({bclk, ws}), 0);
        // R5 R9 sweep: small dividers and slot lengths, zeros included.
        for (int hd = 0; hd <= 3; hd++)
            for (int ll = 0; ll <= 4; ll++)
                for (int rl = 0; rl <= 4; rl++)
                    run_cfg(hd, ll, rl);
        // R11: common word lengths, asymmetric pairs.
        run_cfg(1, 16, 16);
        run_cfg(1, 16, 18);
        run_cfg(2, 20, 24);
        run_cfg(1, 24, 18);
        run_cfg(3, 18, 20);
        run_cfg(1, 63, 5);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule